// File: doc/BRIEF.md
# Serial ATA Port Error and Diagnostic Status Register

This block is the error and diagnostic status word for a single serial ATA port. It is 32 bits wide. The upper half records diagnostic conditions reported by the PHY, link and transport logic. The lower half records error conditions that host software acts on. Each condition arrives as a one-cycle pulse on its own input. The pulse sets a fixed bit, and that bit stays set until software writes a one to it.

Several results are derived from the register contents. A stop-transfer output halts the current transfer while any serious error bit is set. A device-exchange status and a PhyRdy-change status are forwarded to the port interrupt logic. An interrupt request is raised from the PhyRdy-change status when its enable input is high.

The block watches the PhyRdy level itself and flags every change of that level. The host side is a plain register port: a write strobe with write data, and a read data bus that always shows the current register value.

Top module: `perr_status_reg`

## Requirements
- R1: After reset the register reads 32'h0000_0000, and stop_xfer, conn_chg_sts, phyrdy_chg_sts and irq are all low.
- R2: Each event pulse sets its bit at the clock edge where it is sampled, and the bit then holds at one. The bit positions are: ev_fis_unknown 25, ev_trans_state 24, ev_link_seq 23, ev_hs_rerr 22, ev_crc 21, ev_dec_err 19, ev_comm_wake 18, ev_phy_int 17, ev_int_abort 11, ev_proto 10, ev_persist 9, ev_transient 8, ev_rec_comm 1, ev_rec_data 0.
- R3: A write with a one in an implemented bit clears that bit at the write's clock edge. A zero in the write data leaves the bit unchanged.
- R4: Bits 31:27, 20 (disparity, unused), 15:12 and 7:2 always read zero. No write and no event changes them. The implemented-bit mask is 32'h07EF_0F03.
- R5: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: ev_cominit sets bit 26 (device exchanged). conn_chg_sts always equals bit 26.
- R7: A change of phy_ready between two consecutive sampled clock edges sets bit 16. Holding phy_ready steady through reset and after it reports no change.
- R8: phyrdy_chg_sts always equals bit 16. irq is high exactly when bit 16 is set and irq_en is high.
- R9: stop_xfer is high exactly when any of bits 11:8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_fis_unknown | input | 1 | Frame of unknown type received with good CRC |
| ev_trans_state | input | 1 | Transport state transition error |
| ev_link_seq | input | 1 | Link sequence error |
| ev_hs_rerr | input | 1 | Negative handshake received for a sent frame |
| ev_crc | input | 1 | Link CRC error |
| ev_dec_err | input | 1 | 10b-to-8b decode error |
| ev_comm_wake | input | 1 | Comm wake seen by the PHY |
| ev_phy_int | input | 1 | PHY internal error |
| ev_cominit | input | 1 | COMINIT received |
| ev_int_abort | input | 1 | Memory master or target abort |
| ev_proto | input | 1 | Protocol violation |
| ev_persist | input | 1 | Persistent communication or integrity error |
| ev_transient | input | 1 | Transient data integrity error |
| ev_rec_comm | input | 1 | Recovered communication loss |
| ev_rec_data | input | 1 | Recovered data integrity error |
| phy_ready | input | 1 | PHY ready level |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 32 | Write data, ones clear bits |
| bus_rd_data | output | 32 | Current register value |
| irq_en | input | 1 | PhyRdy-change interrupt enable |
| stop_xfer | output | 1 | Halt the current transfer |
| conn_chg_sts | output | 1 | Device-exchange status |
| phyrdy_chg_sts | output | 1 | PhyRdy-change status |
| irq | output | 1 | Interrupt request |

## Verification
Every register bit changes at the clock edge that samples its event or write, so the new value is visible one edge after the inputs are driven. A PhyRdy change also shows up one edge after the new level is first sampled. The derived outputs stop_xfer, conn_chg_sts, phyrdy_chg_sts and irq follow the register with no extra register stage, so they are due in the same cycle as the bit. The bench drives inputs on the falling edge, advances its model at the rising edge, and compares every output on the next falling edge. No result is ever sampled before its edge has passed.

// File: rtl/perr_pkg.sv
// perr_pkg
// Bit positions and derived masks for the port error status word.
// Assumes a 32-bit register; the positions are fixed by the port's
// software view, so they are constants rather than parameters.
package perr_pkg;
    localparam int REG_W = 32;

    localparam int B_EXCHG     = 26;
    localparam int B_FIS_UNK   = 25;
    localparam int B_TRANS_ST  = 24;
    localparam int B_LINK_SEQ  = 23;
    localparam int B_HS_RERR   = 22;
    localparam int B_CRC       = 21;
    localparam int B_DEC_ERR   = 19;
    localparam int B_COMM_WAKE = 18;
    localparam int B_PHY_INT   = 17;
    localparam int B_PHYRDY_CH = 16;
    localparam int B_INT_ABORT = 11;
    localparam int B_PROTO     = 10;
    localparam int B_PERSIST   = 9;
    localparam int B_TRANSIENT = 8;
    localparam int B_REC_COMM  = 1;
    localparam int B_REC_DATA  = 0;

    // Lowest and highest bit of the serious-error group that halts transfers.
    localparam int STOP_LO = B_TRANSIENT;
    localparam int STOP_HI = B_INT_ABORT;

    localparam logic [REG_W-1:0] IMPL_MASK =
          (REG_W'(1) << B_EXCHG)     | (REG_W'(1) << B_FIS_UNK)
        | (REG_W'(1) << B_TRANS_ST)  | (REG_W'(1) << B_LINK_SEQ)
        | (REG_W'(1) << B_HS_RERR)   | (REG_W'(1) << B_CRC)
        | (REG_W'(1) << B_DEC_ERR)   | (REG_W'(1) << B_COMM_WAKE)
        | (REG_W'(1) << B_PHY_INT)   | (REG_W'(1) << B_PHYRDY_CH)
        | (REG_W'(1) << B_INT_ABORT) | (REG_W'(1) << B_PROTO)
        | (REG_W'(1) << B_PERSIST)   | (REG_W'(1) << B_TRANSIENT)
        | (REG_W'(1) << B_REC_COMM)  | (REG_W'(1) << B_REC_DATA);
endpackage

// File: rtl/perr_phy_watch.sv
// perr_phy_watch
// Flags a change of the PHY ready level. It compares the level with a
// copy taken at the previous edge. The copy also loads during reset, so
// nothing is flagged on reset release. Assumes phy_ready is synchronous
// to clk.
module perr_phy_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_ready,
    output logic change
);
    logic prev_q;

    // Track the last sampled level; it also loads in reset on purpose.
    always_ff @(posedge clk) begin
        prev_q <= phy_ready;
    end

    // A change is any difference from the last sampled level.
    always_comb begin
        change = rst_n & (phy_ready ^ prev_q);
    end
endmodule

// File: rtl/perr_event_map.sv
// perr_event_map
// Routes the individual event pulses onto a set vector that is aligned
// to the status word. Assumes every input is a single-cycle pulse.
// Holes in the map stay zero.
module perr_event_map
    import perr_pkg::*;
(
    input  logic             ev_fis_unknown,
    input  logic             ev_trans_state,
    input  logic             ev_link_seq,
    input  logic             ev_hs_rerr,
    input  logic             ev_crc,
    input  logic             ev_dec_err,
    input  logic             ev_comm_wake,
    input  logic             ev_phy_int,
    input  logic             ev_cominit,
    input  logic             phy_change,
    input  logic             ev_int_abort,
    input  logic             ev_proto,
    input  logic             ev_persist,
    input  logic             ev_transient,
    input  logic             ev_rec_comm,
    input  logic             ev_rec_data,
    output logic [REG_W-1:0] set_vec
);
    // Place each event at its fixed register position.
    always_comb begin
        set_vec              = '0;
        set_vec[B_EXCHG]     = ev_cominit;
        set_vec[B_FIS_UNK]   = ev_fis_unknown;
        set_vec[B_TRANS_ST]  = ev_trans_state;
        set_vec[B_LINK_SEQ]  = ev_link_seq;
        set_vec[B_HS_RERR]   = ev_hs_rerr;
        set_vec[B_CRC]       = ev_crc;
        set_vec[B_DEC_ERR]   = ev_dec_err;
        set_vec[B_COMM_WAKE] = ev_comm_wake;
        set_vec[B_PHY_INT]   = ev_phy_int;
        set_vec[B_PHYRDY_CH] = phy_change;
        set_vec[B_INT_ABORT] = ev_int_abort;
        set_vec[B_PROTO]     = ev_proto;
        set_vec[B_PERSIST]   = ev_persist;
        set_vec[B_TRANSIENT] = ev_transient;
        set_vec[B_REC_COMM]  = ev_rec_comm;
        set_vec[B_REC_DATA]  = ev_rec_data;
    end
endmodule

// File: rtl/perr_w1c_bank.sv
// perr_w1c_bank
// A row of sticky write-one-to-clear bits. Only the bits marked in MASK
// get a flop; the rest are tied to zero. When a set and a clear hit the
// same bit in one cycle, the set wins.
module perr_w1c_bank #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic bit_q;

            // Sticky bit: set beats clear, clear needs a written one.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_vec[i])
                    bit_q <= 1'b1;
                else if (wr_en && wr_data[i])
                    bit_q <= 1'b0;
            end
            assign q[i] = bit_q;

            // R2, R5: an event always leaves its bit set.
            a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> q[i]);
            // R3: a written one with no event clears the bit.
            a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_vec[i] && wr_en && wr_data[i]) |=> !q[i]);
            // R3: with neither event nor written one, the bit holds.
            a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_vec[i] && !(wr_en && wr_data[i])) |=> $stable(q[i]));
        end else begin : g_rsvd
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/perr_status_reg.sv
// perr_status_reg
// Error and diagnostic status word for one serial ATA port. It latches
// event pulses into sticky write-one-to-clear bits and derives the
// stop-transfer, exchange, PhyRdy-change and interrupt outputs.
// Assumes all inputs are synchronous to clk, and events are one-cycle
// pulses.
module perr_status_reg
    import perr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_fis_unknown,
    input  logic             ev_trans_state,
    input  logic             ev_link_seq,
    input  logic             ev_hs_rerr,
    input  logic             ev_crc,
    input  logic             ev_dec_err,
    input  logic             ev_comm_wake,
    input  logic             ev_phy_int,
    input  logic             ev_cominit,
    input  logic             ev_int_abort,
    input  logic             ev_proto,
    input  logic             ev_persist,
    input  logic             ev_transient,
    input  logic             ev_rec_comm,
    input  logic             ev_rec_data,
    input  logic             phy_ready,
    input  logic             bus_wr_en,
    input  logic [REG_W-1:0] bus_wr_data,
    output logic [REG_W-1:0] bus_rd_data,
    input  logic             irq_en,
    output logic             stop_xfer,
    output logic             conn_chg_sts,
    output logic             phyrdy_chg_sts,
    output logic             irq
);
    logic             phy_change;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] status_q;

    perr_phy_watch u_phy_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_ready (phy_ready),
        .change    (phy_change)
    );

    perr_event_map u_event_map (
        .ev_fis_unknown (ev_fis_unknown),
        .ev_trans_state (ev_trans_state),
        .ev_link_seq    (ev_link_seq),
        .ev_hs_rerr     (ev_hs_rerr),
        .ev_crc         (ev_crc),
        .ev_dec_err     (ev_dec_err),
        .ev_comm_wake   (ev_comm_wake),
        .ev_phy_int     (ev_phy_int),
        .ev_cominit     (ev_cominit),
        .phy_change     (phy_change),
        .ev_int_abort   (ev_int_abort),
        .ev_proto       (ev_proto),
        .ev_persist     (ev_persist),
        .ev_transient   (ev_transient),
        .ev_rec_comm    (ev_rec_comm),
        .ev_rec_data    (ev_rec_data),
        .set_vec        (set_vec)
    );

    perr_w1c_bank #(
        .W    (REG_W),
        .MASK (IMPL_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .q       (status_q)
    );

    // Drive the read bus and the derived status and halt outputs.
    always_comb begin
        bus_rd_data    = status_q;
        stop_xfer      = |status_q[STOP_HI:STOP_LO];
        conn_chg_sts   = status_q[B_EXCHG];
        phyrdy_chg_sts = status_q[B_PHYRDY_CH];
        irq            = status_q[B_PHYRDY_CH] & irq_en;
    end

    // R9: a transient integrity error halts the transfer on the next cycle.
    a_r9_stop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        ev_transient |=> stop_xfer);
    // R6: COMINIT raises the connect-change status.
    a_r6_exchange_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cominit |=> conn_chg_sts);
    // R7: a sampled change of the PHY ready level raises the change status.
    a_r7_phyrdy_change: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ready != $past(phy_ready)) |=> phyrdy_chg_sts);
    // R4: reserved positions never read as one.
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_data & ~IMPL_MASK) == '0);
endmodule

// File: tb/perr_status_reg_tb.sv
module perr_status_reg_tb;
    localparam int  CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h07EF_0F03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ev = '0;
    logic        phy_ready = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        irq_en = 1'b0;
    logic        stop_xfer, conn_chg_sts, phyrdy_chg_sts, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q = '0;
    logic        phy_last = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    perr_status_reg u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_fis_unknown (ev[13]),
        .ev_trans_state (ev[12]),
        .ev_link_seq    (ev[11]),
        .ev_hs_rerr     (ev[10]),
        .ev_crc         (ev[9]),
        .ev_dec_err     (ev[8]),
        .ev_comm_wake   (ev[7]),
        .ev_phy_int     (ev[6]),
        .ev_cominit     (ev[14]),
        .ev_int_abort   (ev[5]),
        .ev_proto       (ev[4]),
        .ev_persist     (ev[3]),
        .ev_transient   (ev[2]),
        .ev_rec_comm    (ev[1]),
        .ev_rec_data    (ev[0]),
        .phy_ready      (phy_ready),
        .bus_wr_en      (bus_wr_en),
        .bus_wr_data    (bus_wr_data),
        .bus_rd_data    (bus_rd_data),
        .irq_en         (irq_en),
        .stop_xfer      (stop_xfer),
        .conn_chg_sts   (conn_chg_sts),
        .phyrdy_chg_sts (phyrdy_chg_sts),
        .irq            (irq)
    );

    // Bench event vector to register positions, taken from R2, R6 and R7.
    function automatic logic [31:0] ev_to_bits(logic [14:0] e, logic phy_chg);
        logic [31:0] v = '0;
        v[0]  = e[0];  v[1]  = e[1];  v[8]  = e[2];  v[9]  = e[3];
        v[10] = e[4];  v[11] = e[5];  v[17] = e[6];  v[18] = e[7];
        v[19] = e[8];  v[21] = e[9];  v[22] = e[10]; v[23] = e[11];
        v[24] = e[12]; v[25] = e[13]; v[26] = e[14]; v[16] = phy_chg;
        return v;
    endfunction

    // Next register value: clear by written ones, then set wins, masked (R3, R4, R5).
    function automatic logic [31:0] model_next(logic [31:0] cur, logic [31:0] setv,
                                               logic wr, logic [31:0] wd);
        logic [31:0] clr = wr ? wd : 32'h0;
        return ((cur & ~clr) | setv) & MASK;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, expv);
        end
    endtask

    // One cycle: drive at the falling edge, advance the model at the rising
    // edge, compare at the next falling edge.
    task automatic step(logic [14:0] e, logic phy, logic wr, logic [31:0] wd, logic en);
        logic [31:0] nxt;
        ev = e; phy_ready = phy; bus_wr_en = wr; bus_wr_data = wd; irq_en = en;
        nxt = model_next(exp_q, ev_to_bits(e, phy != phy_last), wr, wd);
        @(posedge clk);
        exp_q = nxt;
        phy_last = phy;
        @(negedge clk);
        ev = '0; bus_wr_en = 1'b0; bus_wr_data = '0;
        check("R2 register value", bus_rd_data, exp_q);
        check("R9 stop_xfer", 32'(stop_xfer), 32'(|exp_q[11:8]));
        check("R6 conn_chg_sts", 32'(conn_chg_sts), 32'(exp_q[26]));
        check("R8 phyrdy_chg_sts", 32'(phyrdy_chg_sts), 32'(exp_q[16]));
        check("R8 irq", 32'(irq), 32'(exp_q[16] & en));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A7A_0001));
        repeat (4) @(negedge clk);
        check("R1 reset value", bus_rd_data, 32'h0);
        check("R1 outputs low", {28'h0, stop_xfer, conn_chg_sts, phyrdy_chg_sts, irq}, 32'h0);
        rst_n = 1'b1;
        // R7: level held through reset release, so no change may be reported.
        step('0, 1'b1, 1'b0, 32'h0, 1'b1);
        check("R7 no change after reset", 32'(bus_rd_data[16]), 32'h0);

        // R9 with R4: a transient error halts, a write to reserved bits only changes nothing.
        step(15'h0004, 1'b1, 1'b0, 32'h0, 1'b0);
        check("R9 stop after bit 8", 32'(stop_xfer), 32'h1);
        step('0, 1'b1, 1'b1, ~MASK, 1'b0);
        check("R4 reserved write ignored", bus_rd_data, 32'h0000_0100);

        // R3: a zero write keeps the bit, a one write clears it.
        step('0, 1'b1, 1'b1, 32'h0, 1'b0);
        check("R3 zero write keeps", bus_rd_data, 32'h0000_0100);
        step('0, 1'b1, 1'b1, 32'h0000_0100, 1'b0);
        check("R3 one write clears", bus_rd_data, 32'h0);
        check("R9 stop released", 32'(stop_xfer), 32'h0);

        // R5: a CRC event and a clear of bit 21 in the same cycle.
        step(15'h0200, 1'b1, 1'b1, 32'h0020_0000, 1'b0);
        check("R5 set wins", 32'(bus_rd_data[21]), 32'h1);
        step('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);

        // R6: COMINIT sets bit 26.
        step(15'h4000, 1'b1, 1'b0, 32'h0, 1'b0);
        check("R6 exchanged bit", bus_rd_data, 32'h0400_0000);
        check("R6 conn status", 32'(conn_chg_sts), 32'h1);

        // R7, R8: a level drop sets bit 16; irq follows the enable.
        step('0, 1'b0, 1'b0, 32'h0, 1'b0);
        check("R7 change seen", 32'(bus_rd_data[16]), 32'h1);
        check("R8 irq masked", 32'(irq), 32'h0);
        step('0, 1'b0, 1'b0, 32'h0, 1'b1);
        check("R8 irq enabled", 32'(irq), 32'h1);
        step('0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1);
        check("R7 steady level no set", 32'(bus_rd_data[16]), 32'h0);

        // R2: every event on its own sets exactly its bit.
        for (int k = 0; k < 14; k++) begin
            step(15'(1) << k, 1'b0, 1'b0, 32'h0, 1'b0);
            check("R2 single event", bus_rd_data, ev_to_bits(15'(1) << k, 1'b0));
            step('0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        end

        // Random mix of events, level changes and clears (R2 to R9).
        for (int c = 0; c < 3000; c++) begin
            logic [14:0] e;
            logic        p;
            logic        w;
            logic [31:0] d;
            for (int b = 0; b < 15; b++) e[b] = ($urandom_range(15) == 0);
            p = ($urandom_range(9) == 0) ? ~phy_last : phy_last;
            w = ($urandom_range(3) == 0);
            d = $urandom();
            step(e, p, w, d, 1'($urandom_range(1)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule